// File: doc/BRIEF.md
# Dual Registered Bus Transceiver

This block joins two bidirectional data buses, A and B, through a pair of one-way paths. Each path owns a capture register with its own clock: the A-to-B register samples bus A, and the B-to-A register samples bus B. A per-path select picks what the path presents to the far bus. It is either the live word arriving from the near bus or the word last captured in that path's register. The inputs are always live, so captures happen on every rising edge of a register clock, even while both buses are released.

An active-low enable and a direction input decide which bus, if any, the block drives. Only one bus is driven at any time, and the other is treated as an input. A parameter builds an inverting variant, in which both the live and the stored paths carry the complement of the source bus. The buses appear as split in, out and output-enable signals. Pad-level tri-state drivers sit outside the block. The `*_out` value of a bus that is not driven is forced to zero.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab` the A-to-B register loads `a_in` (complemented when INVERT=1), whatever the levels of `en_n`, `dir`, `sel_ab` and `sel_ba`.
- R2: On every rising edge of `clk_ba` the B-to-A register loads `b_in` (complemented when INVERT=1), whatever the levels of `en_n`, `dir`, `sel_ab` and `sel_ba`.
- R3: While bus B is driven, `sel_ab`=0 makes `b_out` follow `a_in` combinationally (complemented when INVERT=1), and `sel_ab`=1 makes `b_out` equal the A-to-B register.
- R4: While bus A is driven, `sel_ba`=0 makes `a_out` follow `b_in` combinationally (complemented when INVERT=1), and `sel_ba`=1 makes `a_out` equal the B-to-A register.
- R5: With `en_n`=1, `a_oe` and `b_oe` are both 0 and `a_out` and `b_out` are all zeros, while captures from either bus still take place.
- R6: With `en_n`=0, `dir`=0 gives `a_oe`=1 and `b_oe`=0, and `dir`=1 gives `b_oe`=1 and `a_oe`=0. The enables follow the control inputs combinationally, with no clock edge in between.
- R7: `a_oe` and `b_oe` are never 1 together, and the `*_out` of the bus that is not driven is all zeros.
- R8: INVERT=0 forwards and stores true data. INVERT=1 forwards and stores the bitwise complement on both the live and the stored path.
- R9: A register keeps its word across rising edges of the other path's clock, and across changes of its own source bus between its own clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register, rising edge |
| clk_ba | input | 1 | Capture clock of the B-to-A register, rising edge |
| en_n | input | 1 | Active-low output enable; high releases both buses |
| dir | input | 1 | Driven-bus choice when enabled: 0 drives A, 1 drives B |
| sel_ab | input | 1 | Source for bus B: 0 live bus A, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for bus A: 0 live bus B, 1 stored B-to-A word |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value driven onto bus A; zero when not driven |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value driven onto bus B; zero when not driven |
| b_oe | output | 1 | Bus B drive enable |

## Verification
The bench loads both registers while both buses are released. A design that gated capture with the enable would then replay stale words once a bus is enabled. It pulses one path's clock while the other path's stored word is on display. Swapped or shared clocks would corrupt the displayed word. It flips the select with no clock edge to show that live and stored sources switch at once, and it sweeps every enable and direction combination to catch a bus driven in the wrong mode or both buses driven at once. A true and an inverting instance run side by side on the same stimulus. A variant that complemented only one of the two paths would show up on the live checks or on the replay checks.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;

   // Which bus the block currently drives.
   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_A    = 2'd1,
      DRV_B    = 2'd2
   } xcvr_drive_e;

endpackage

// File: rtl/xcvr_polarity.sv
// Optional bitwise complement, chosen at elaboration.
module xcvr_polarity #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (INVERT != 0) begin : g_invert
         assign q = ~d;
      end else begin : g_pass
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/xcvr_store.sv
// Edge-triggered capture register, no reset by design.
module xcvr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/xcvr_path.sv
// One direction: polarity stage, capture register and live/stored mux.
module xcvr_path #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] src,
   input  logic             use_stored,
   output logic [WIDTH-1:0] path_out
);

   logic [WIDTH-1:0] live_w;
   logic [WIDTH-1:0] held_w;

   xcvr_polarity #(.WIDTH(WIDTH), .INVERT(INVERT)) pol_i (
      .d (src),
      .q (live_w)
   );

   // The register takes the already-polarised word, so live and stored
   // paths always agree in sense.
   xcvr_store #(.WIDTH(WIDTH)) store_i (
      .clk (clk),
      .d   (live_w),
      .q   (held_w)
   );

   always_comb begin
      if (use_stored) path_out = held_w;
      else            path_out = live_w;
   end

endmodule

// File: rtl/xcvr_drive_ctl.sv
// Decodes enable and direction into a single driven-bus choice.
module xcvr_drive_ctl
   import dual_reg_xcvr_pkg::*;
(
   input  logic        en_n,
   input  logic        dir,
   output xcvr_drive_e drive,
   output logic        a_oe,
   output logic        b_oe
);

   always_comb begin
      if (en_n)     drive = DRV_NONE;
      else if (dir) drive = DRV_B;
      else          drive = DRV_A;
   end

   assign a_oe = (drive == DRV_A);
   assign b_oe = (drive == DRV_B);

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
   import dual_reg_xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             en_n,
   input  logic             dir,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   localparam logic [WIDTH-1:0] IDLE_WORD = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dual_reg_xcvr: WIDTH must be at least 1");
      end
      if (INVERT != 0 && INVERT != 1) begin : g_bad_invert
         $error("dual_reg_xcvr: INVERT must be 0 or 1");
      end
   endgenerate

   xcvr_drive_e      drive_w;
   logic [WIDTH-1:0] to_b_w;
   logic [WIDTH-1:0] to_a_w;

   xcvr_drive_ctl ctl_i (
      .en_n  (en_n),
      .dir   (dir),
      .drive (drive_w),
      .a_oe  (a_oe),
      .b_oe  (b_oe)
   );

   xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) path_ab_i (
      .clk        (clk_ab),
      .src        (a_in),
      .use_stored (sel_ab),
      .path_out   (to_b_w)
   );

   xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) path_ba_i (
      .clk        (clk_ba),
      .src        (b_in),
      .use_stored (sel_ba),
      .path_out   (to_a_w)
   );

   assign b_out = (drive_w == DRV_B) ? to_b_w : IDLE_WORD;
   assign a_out = (drive_w == DRV_A) ? to_a_w : IDLE_WORD;

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             en_n,
   input logic             dir,
   input logic             sel_ab,
   input logic             sel_ba,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);

   localparam logic [WIDTH-1:0] FLIP = (INVERT != 0) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

   // Registers have no reset; each checker arms after its clock's first edge.
   logic armed_ab = 1'b0;
   logic armed_ba = 1'b0;

   always_ff @(posedge clk_ab) armed_ab <= 1'b1;
   always_ff @(posedge clk_ba) armed_ba <= 1'b1;

   assert_store_ab_R1: assert property (@(posedge clk_ab) disable iff (!armed_ab)
      (sel_ab && b_oe) |-> (b_out == ($past(a_in) ^ FLIP)));

   assert_store_ba_R2: assert property (@(posedge clk_ba) disable iff (!armed_ba)
      (sel_ba && a_oe) |-> (a_out == ($past(b_in) ^ FLIP)));

   assert_live_ab_R3: assert property (@(posedge clk_ab) disable iff (!armed_ab)
      (b_oe && !sel_ab) |-> (b_out == (a_in ^ FLIP)));

   assert_live_ba_R4: assert property (@(posedge clk_ba) disable iff (!armed_ba)
      (a_oe && !sel_ba) |-> (a_out == (b_in ^ FLIP)));

   assert_isolate_R5: assert property (@(posedge clk_ab) disable iff (!armed_ab)
      en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

   assert_direction_R6: assert property (@(posedge clk_ba) disable iff (!armed_ba)
      !en_n |-> (a_oe == !dir && b_oe == dir));

   assert_one_bus_R7: assert property (@(posedge clk_ab) disable iff (!armed_ab)
      !(a_oe && b_oe) && (a_oe || a_out == '0) && (b_oe || b_out == '0));

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) chk_i (
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .en_n   (en_n),
   .dir    (dir),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_oe   (b_oe)
);

// File: tb/dual_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;

   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic         clk_ab = 1'b0;
   logic         clk_ba = 1'b0;
   logic         en_n   = 1'b1;
   logic         dir    = 1'b0;
   logic         sel_ab = 1'b0;
   logic         sel_ba = 1'b0;
   logic [W-1:0] a_in   = '0;
   logic [W-1:0] b_in   = '0;

   logic [W-1:0] a_out_t, b_out_t, a_out_n, b_out_n;
   logic         a_oe_t, b_oe_t, a_oe_n, b_oe_n;

   dual_reg_xcvr #(.WIDTH(W), .INVERT(0)) dut_i (
      .clk_ab (clk_ab), .clk_ba (clk_ba), .en_n (en_n), .dir (dir),
      .sel_ab (sel_ab), .sel_ba (sel_ba),
      .a_in (a_in), .a_out (a_out_t), .a_oe (a_oe_t),
      .b_in (b_in), .b_out (b_out_t), .b_oe (b_oe_t)
   );

   dual_reg_xcvr #(.WIDTH(W), .INVERT(1)) dut_inv_i (
      .clk_ab (clk_ab), .clk_ba (clk_ba), .en_n (en_n), .dir (dir),
      .sel_ab (sel_ab), .sel_ba (sel_ba),
      .a_in (a_in), .a_out (a_out_n), .a_oe (a_oe_n),
      .b_in (b_in), .b_out (b_out_n), .b_oe (b_oe_n)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [W-1:0] m_ab;   // true-sense word expected in the A-to-B register
   logic [W-1:0] m_ba;   // true-sense word expected in the B-to-A register

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Checks a driven bus on both variants: true sense and complement (R8).
   task automatic check_word(string req, logic [W-1:0] act_t, logic [W-1:0] act_n,
                             logic [W-1:0] exp);
      check({req, " true"}, act_t, exp);
      check({req, " R8 inverted"}, act_n, ~exp);
   endtask

   task automatic check_oe(string req, logic exp_a, logic exp_b);
      check({req, " a_oe"}, {{(W-1){1'b0}}, a_oe_t}, {{(W-1){1'b0}}, exp_a});
      check({req, " b_oe"}, {{(W-1){1'b0}}, b_oe_t}, {{(W-1){1'b0}}, exp_b});
      check({req, " inv a_oe"}, {{(W-1){1'b0}}, a_oe_n}, {{(W-1){1'b0}}, exp_a});
      check({req, " inv b_oe"}, {{(W-1){1'b0}}, b_oe_n}, {{(W-1){1'b0}}, exp_b});
   endtask

   task automatic set_ctl(logic e, logic d, logic sa, logic sb);
      @(negedge clk);
      en_n = e; dir = d; sel_ab = sa; sel_ba = sb;
      #1;
   endtask

   task automatic pulse_ab;
      @(negedge clk); clk_ab = 1'b1;
      @(negedge clk); clk_ab = 1'b0;
      #1;
   endtask

   task automatic pulse_ba;
      @(negedge clk); clk_ba = 1'b1;
      @(negedge clk); clk_ba = 1'b0;
      #1;
   endtask

   // Released buses, then loads while released.
   task automatic t_isolate;
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      check_oe("R5 idle", 1'b0, 1'b0);
      check("R5 idle a_out", a_out_t, '0);
      check("R5 idle b_out", b_out_t, '0);
      @(negedge clk); a_in = 8'h3C; pulse_ab; m_ab = 8'h3C;
      @(negedge clk); b_in = 8'hA5; pulse_ba; m_ba = 8'hA5;
      set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
      check_oe("R5 idle after load", 1'b0, 1'b0);
      check("R5 inv a_out", a_out_n, '0);
      check("R5 inv b_out", b_out_n, '0);
   endtask

   // Replay of words captured while isolated.
   task automatic t_stored_replay;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
      check_oe("R6 dir=1", 1'b0, 1'b1);
      check_word("R1 R3 stored on B", b_out_t, b_out_n, m_ab);
      check("R7 A released", a_out_t, '0);
      @(negedge clk); a_in = 8'hFF; #1;
      check_word("R9 source change no edge", b_out_t, b_out_n, m_ab);
      set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
      check_oe("R6 dir=0", 1'b1, 1'b0);
      check_word("R2 R4 stored on A", a_out_t, a_out_n, m_ba);
      check("R7 B released", b_out_t, '0);
   endtask

   task automatic t_live_ab;
      logic [W-1:0] pats [5] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h81};
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      foreach (pats[i]) begin
         @(negedge clk); a_in = pats[i]; #1;
         check_word("R3 live A to B", b_out_t, b_out_n, pats[i]);
         check("R7 A released live", a_out_n, '0);
      end
   endtask

   task automatic t_live_ba;
      logic [W-1:0] pats [5] = '{8'h01, 8'hFE, 8'h33, 8'hCC, 8'h96};
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      foreach (pats[i]) begin
         @(negedge clk); b_in = pats[i]; #1;
         check_word("R4 live B to A", a_out_t, a_out_n, pats[i]);
         check("R7 B released live", b_out_n, '0);
      end
   endtask

   // Capture while the same or the opposite bus is being driven.
   task automatic t_capture_while_driving;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
      @(negedge clk); a_in = 8'hC3; pulse_ab; m_ab = 8'hC3;
      check_word("R1 capture while driving B", b_out_t, b_out_n, m_ab);
      set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
      @(negedge clk); b_in = 8'h7E; pulse_ba; m_ba = 8'h7E;
      check_word("R2 capture while driving A", a_out_t, a_out_n, m_ba);
   endtask

   // Edge on the other path's clock leaves a register untouched.
   task automatic t_cross_clock;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
      @(negedge clk); a_in = 8'h11; b_in = 8'h22; pulse_ba; m_ba = 8'h22;
      check_word("R9 A-to-B held over clk_ba", b_out_t, b_out_n, m_ab);
      set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
      check_word("R2 B-to-A took clk_ba", a_out_t, a_out_n, m_ba);
      @(negedge clk); b_in = 8'h44; pulse_ab; m_ab = 8'h11;
      check_word("R9 B-to-A held over clk_ab", a_out_t, a_out_n, m_ba);
   endtask

   // Source select switches with no clock edge.
   task automatic t_sel_switch;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      @(negedge clk); a_in = 8'h0F; #1;
      check_word("R3 sel_ab=0 live", b_out_t, b_out_n, 8'h0F);
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check_word("R3 sel_ab=1 stored", b_out_t, b_out_n, m_ab);
      set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
      check_word("R4 sel_ba=0 live", a_out_t, a_out_n, 8'h44);
   endtask

   task automatic t_ctl_sweep;
      for (int e = 0; e < 2; e++) begin
         for (int d = 0; d < 2; d++) begin
            set_ctl(e[0], d[0], 1'b0, 1'b0);
            if (e == 1) check_oe("R5 R7 sweep", 1'b0, 1'b0);
            else        check_oe("R6 R7 sweep", ~d[0], d[0]);
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      m_ab = '0;
      m_ba = '0;
      repeat (2) @(negedge clk);
      t_isolate;
      t_stored_replay;
      t_live_ab;
      t_live_ba;
      t_capture_while_driving;
      t_cross_clock;
      t_sel_switch;
      t_ctl_sweep;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule